// File: doc/BRIEF.md
# Receive Character Buffer with Occupancy Threshold

This block sits between a serial receiver's deserializer and the register-read side of a UART. Every character the deserializer delivers is stored with its status: eight data bits, an optional ninth data bit, a noise flag and a parity-error flag. These are kept together and presented together when the entry reaches the head. The block keeps a live occupancy count that software can read. Software empties the buffer by reading the data register once for each entry the count reports.

Instead of requesting service as soon as anything arrives, the block asserts its data-ready request only once occupancy reaches a programmable watermark. This lets software take characters in batches. A batch smaller than the watermark could otherwise stay in the buffer indefinitely. To prevent that, an idle-line pulse from the receiver sets an idle flag, which tells software to drain what is left. Two sizes are intended: eight entries, and a single entry that acts as a plain double-buffered receiver.

Top module: `rx_watermark_fifo`

## Requirements
- R1: After reset the count is 0 and data-ready, the idle flag and the overflow flag are all 0. The head fields read as all zero.
- R2: Entries leave in arrival order. The head presents data, ninth bit, noise and parity-error exactly as they were written with that character. In bench notation the entry packs as {parity, noise, bit9, data[7:0]}.
- R3: An accepted write raises the count by one. A read of a non-empty buffer removes the head entry and lowers the count by one. A write and a read in the same cycle on a non-empty buffer leave the count unchanged.
- R4: Data-ready is 1 exactly when the count is greater than or equal to the effective watermark. With the watermark at 4 on the 8-entry size, it rises after the fourth character.
- R5: A watermark of 0 acts as 1. A watermark above the depth acts as the depth.
- R6: A read of an empty buffer leaves the count at 0, and the head keeps showing the last entry that was removed.
- R7: A write to a full buffer with no read in the same cycle is discarded and sets the overflow flag. The flag stays set until the overflow-clear strobe, and a new drop in the same cycle as the clear wins over the clear.
- R8: An idle-detect pulse sets the idle flag. The flag clears on an acknowledge strobe, or on a read that leaves the buffer empty. A pulse in the same cycle wins over a clear.
- R9: With a depth of 1 the block follows R1 to R8 with a single entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Received character strobe |
| wr_data | input | DW | Received data bits |
| wr_bit9 | input | 1 | Ninth data bit |
| wr_noise | input | 1 | Noise detected on this character |
| wr_parerr | input | 1 | Parity error on this character |
| idle_pulse | input | 1 | Idle-line detected |
| idle_ack | input | 1 | Clears the idle flag |
| ovf_clear | input | 1 | Clears the overflow flag |
| wmark | input | CW | Watermark setting |
| rd_strobe | input | 1 | Data-register read, removes the head entry |
| head_data | output | DW | Head entry data |
| head_bit9 | output | 1 | Head entry ninth bit |
| head_noise | output | 1 | Head entry noise flag |
| head_parerr | output | 1 | Head entry parity-error flag |
| count | output | CW | Entries held |
| data_ready | output | 1 | Occupancy has reached the watermark |
| idle_flag | output | 1 | Idle line seen, drain remaining entries |
| overflow | output | 1 | Sticky flag for a dropped character |

## Verification
The bench builds two copies side by side, one with DEPTH=8 and one with DEPTH=1, and drives them with the same stimulus. With eight entries, every watermark code from 0 to 15 can be swept against every occupancy from empty to full plus one. This covers both clamping ends and the overflow drop. The single-entry copy reaches full, overflow and the drain-to-empty idle clear on almost every cycle. A long mixed phase of random writes, reads, idle pulses and clears then exercises simultaneous read/write at full and at empty, and reads of an empty buffer.

// File: rtl/rx_watermark_fifo.sv
module rx_watermark_fifo #(
  parameter int DEPTH = 8,
  parameter int DW = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_bit9,
  input  logic          wr_noise,
  input  logic          wr_parerr,
  input  logic          idle_pulse,
  input  logic          idle_ack,
  input  logic          ovf_clear,
  input  logic [CW-1:0] wmark,
  input  logic          rd_strobe,
  output logic [DW-1:0] head_data,
  output logic          head_bit9,
  output logic          head_noise,
  output logic          head_parerr,
  output logic [CW-1:0] count,
  output logic          data_ready,
  output logic          idle_flag,
  output logic          overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = DW + 3;

  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] last_q, head_w;
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] cnt, wm_eff;
  logic          empty, full, pop, push, drop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (DEPTH == 1 || p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  assign pop    = rd_strobe && !empty;
  assign push   = wr_valid && (!full || pop);
  assign drop   = wr_valid && !push;
  assign wm_eff = (wmark == '0) ? CW'(1) : (wmark > CW'(DEPTH)) ? CW'(DEPTH) : wmark;
  assign head_w = empty ? last_q : mem[rp];

  assign {head_parerr, head_noise, head_bit9, head_data} = head_w;
  assign count      = cnt;
  assign data_ready = (cnt >= wm_eff);

  always_ff @(posedge clk)
    if (push) mem[wp] <= {wr_parerr, wr_noise, wr_bit9, wr_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp        <= '0;
      wp        <= '0;
      cnt       <= '0;
      last_q    <= '0;
      overflow  <= 1'b0;
      idle_flag <= 1'b0;
    end else begin
      if (pop) begin
        rp     <= bump(rp);
        last_q <= mem[rp];
      end
      if (push) wp <= bump(wp);
      cnt      <= cnt + CW'(push) - CW'(pop);
      overflow <= drop | (overflow & ~ovf_clear);
      if (idle_pulse) idle_flag <= 1'b1;
      else if (idle_ack || (pop && !push && cnt == CW'(1))) idle_flag <= 1'b0;
    end
  end
endmodule

module rx_watermark_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int DW = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          rd_strobe,
  input logic          idle_pulse,
  input logic          ovf_clear,
  input logic [DW-1:0] head_data,
  input logic [CW-1:0] count,
  input logic          data_ready,
  input logic          idle_flag,
  input logic          overflow
);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_hold_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && rd_strobe && count != '0) |=> $stable(count));
  p_ready_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> (count != '0));
  p_ready_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> data_ready);
  p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !wr_valid && count == '0) |=> (count == '0 && $stable(head_data)));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !rd_strobe && count == CW'(DEPTH)) |=> (overflow && count == CW'(DEPTH)));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clear) |=> overflow);
  p_idle_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |=> idle_flag);
endmodule

bind rx_watermark_fifo rx_watermark_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_strobe(rd_strobe),
  .idle_pulse(idle_pulse), .ovf_clear(ovf_clear), .head_data(head_data),
  .count(count), .data_ready(data_ready), .idle_flag(idle_flag), .overflow(overflow)
);

// File: tb/rx_watermark_fifo_tb.sv
module rx_watermark_fifo_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       wr_valid = 0, wr_bit9 = 0, wr_noise = 0, wr_parerr = 0;
  logic [7:0] wr_data = 0;
  logic       idle_pulse = 0, idle_ack = 0, ovf_clear = 0, rd_strobe = 0;
  logic [3:0] wm = 0;
  logic       wm1;
  assign wm1 = (wm != 0);

  logic [3:0]  c8;
  logic [0:0]  c1;
  logic [7:0]  d8, d1;
  logic        b8, b1, n8, n1, p8, p1, r8, r1, i8, i1, o8, o1;

  rx_watermark_fifo #(.DEPTH(8), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_bit9(wr_bit9),
    .wr_noise(wr_noise), .wr_parerr(wr_parerr), .idle_pulse(idle_pulse), .idle_ack(idle_ack),
    .ovf_clear(ovf_clear), .wmark(wm), .rd_strobe(rd_strobe), .head_data(d8), .head_bit9(b8),
    .head_noise(n8), .head_parerr(p8), .count(c8), .data_ready(r8), .idle_flag(i8), .overflow(o8));

  rx_watermark_fifo #(.DEPTH(1), .DW(8)) dut1_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_bit9(wr_bit9),
    .wr_noise(wr_noise), .wr_parerr(wr_parerr), .idle_pulse(idle_pulse), .idle_ack(idle_ack),
    .ovf_clear(ovf_clear), .wmark(wm1), .rd_strobe(rd_strobe), .head_data(d1), .head_bit9(b1),
    .head_noise(n1), .head_parerr(p1), .count(c1), .data_ready(r1), .idle_flag(i1), .overflow(o1));

  logic [3:0]  cnt_a  [2];
  logic [10:0] head_a [2];
  logic        rdy_a [2], idl_a [2], ovf_a [2];
  assign cnt_a[0] = c8;  assign cnt_a[1] = {3'b0, c1};
  assign head_a[0] = {p8, n8, b8, d8};  assign head_a[1] = {p1, n1, b1, d1};
  assign rdy_a[0] = r8;  assign rdy_a[1] = r1;
  assign idl_a[0] = i8;  assign idl_a[1] = i1;
  assign ovf_a[0] = o8;  assign ovf_a[1] = o1;

  int total = 0, bad = 0;
  int dep [2] = '{8, 1};
  logic [10:0] mq [2][8];
  logic [10:0] mlast [2];
  int mc [2];
  logic movf [2], midle [2];

  task automatic chk(string tag, int k, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s%s depth=%0d act=%0h exp=%0h", (k == 1) ? "R9 " : "", tag, dep[k], act, exp);
    end
  endtask

  function automatic int eff(int k);
    int w = (k == 1) ? int'(wm1) : int'(wm);
    if (w == 0) return 1;
    if (w > dep[k]) return dep[k];
    return w;
  endfunction

  task automatic compare(string rtag);
    for (int k = 0; k < 2; k++) begin
      chk("R3 count", k, cnt_a[k], mc[k]);
      chk("R2 head", k, head_a[k], (mc[k] > 0) ? mq[k][0] : mlast[k]);
      chk({rtag, " ready"}, k, rdy_a[k], int'(mc[k] >= eff(k)));
      chk("R8 idle", k, idl_a[k], midle[k]);
      chk("R7 overflow", k, ovf_a[k], movf[k]);
    end
  endtask

  task automatic step(bit w, logic [10:0] word, bit r, bit ip, bit ia, bit oc, string rtag);
    wr_valid = w; {wr_parerr, wr_noise, wr_bit9, wr_data} = word;
    rd_strobe = r; idle_pulse = ip; idle_ack = ia; ovf_clear = oc;
    for (int k = 0; k < 2; k++) begin
      bit pop = r && mc[k] > 0;
      bit push = w && (mc[k] < dep[k] || pop);
      if (pop) begin
        mlast[k] = mq[k][0];
        for (int j = 0; j < 7; j++) mq[k][j] = mq[k][j+1];
        mc[k]--;
      end
      if (push) begin mq[k][mc[k]] = word; mc[k]++; end
      movf[k] = (w && !push) || (movf[k] && !oc);
      if (ip) midle[k] = 1;
      else if (ia || (pop && mc[k] == 0)) midle[k] = 0;
    end
    @(negedge clk);
    wr_valid = 0; rd_strobe = 0; idle_pulse = 0; idle_ack = 0; ovf_clear = 0;
    compare(rtag);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      mc[k] = 0; mlast[k] = 0; movf[k] = 0; midle[k] = 0;
      for (int j = 0; j < 8; j++) mq[k][j] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 2; k++) begin
      chk("R1 count", k, cnt_a[k], 0);
      chk("R1 head", k, head_a[k], 0);
      chk("R1 ready", k, rdy_a[k], 0);
      chk("R1 idle", k, idl_a[k], 0);
      chk("R1 overflow", k, ovf_a[k], 0);
    end

    for (int w = 0; w < 16; w++) begin
      string t = (w == 0 || w > 8) ? "R5" : "R4";
      wm = 4'(w);
      for (int i = 0; i < 9; i++) step(1, 11'((w * 37 + i * 91) ^ (i << 8)), 0, 0, 0, 0, t);
      step(0, 0, 0, 1, 0, 0, t);
      for (int i = 0; i < 9; i++) step(0, 0, 1, 0, 0, 0, t);
      step(0, 0, 0, 0, 0, 1, t);
    end

    // R6: read while empty keeps last removed head and zero count
    wm = 4;
    step(1, 11'h5A3, 0, 0, 0, 0, "R4");
    step(0, 0, 1, 0, 0, 0, "R4");
    step(0, 0, 1, 0, 0, 0, "R4");
    chk("R6 empty-read head", 0, head_a[0], 11'h5A3);
    chk("R6 empty-read count", 0, cnt_a[0], 0);
    chk("R6 empty-read head", 1, head_a[1], 11'h5A3);

    // R4: watermark 4 -> ready only after fourth character
    for (int i = 0; i < 4; i++) begin
      step(1, 11'(i + 1), 0, 0, 0, 0, "R4");
      chk("R4 ready at wm4", 0, rdy_a[0], int'(i == 3));
    end
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, "R4");

    for (int n = 0; n < 4000; n++) begin
      int rr = int'($urandom % 100);
      if (n % 250 == 0) wm = 4'($urandom);
      step(rr < 55, 11'($urandom), ($urandom % 100) < 50, rr > 95, ($urandom % 100) < 5,
           ($urandom % 100) < 4, "R4");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule